// File: doc/BRIEF.md
# Hashed Page Table Walker

This block translates an effective address into a real address. It looks up the address in a hashed page table held in memory. Before the walk starts, the caller has already resolved the segment: it supplies the virtual segment ID, the segment size (256 MB or 1 TB), the base page shift, the effective address, and the table's base and hash mask. One `start_i` pulse latches these values. The walker then hashes the page number, reads the eight entries of the primary group one at a time, and compares each first doubleword against a tag built from the segment and the address. If no entry matches, it reads the eight entries of the secondary group, which is selected by the complemented hash.

On a hit, the walker sets the referenced bit in the entry's second doubleword, and also the changed bit for a store. It writes that doubleword back only when its value changes. It then reports the real address and the entry index. When neither group matches, it reports a miss. A control input can force the page shift down to 4 KiB regardless of the configured value.

Top module: `hpt_walker`

## Requirements
- R1: While reset is held and while idle, `busy_o`, `done_o`, `rd_req_o` and `wr_req_o` are all low.
- R2: For a 256 MB segment (`seg_1t_i`=0), the hash is the VSID XOR (EA[27:0] >> shift).
- R3: For a 1 TB segment (`seg_1t_i`=1), the hash is the VSID XOR (VSID << 25) XOR (EA[39:0] >> shift).
- R4: The primary group is hash[HASH_W-1:0] AND `htab_mask_i`, and the entry index is group*8+slot. Each read targets `htab_base_i` + index*16, and the base is 16-byte aligned. `rd_data_i` carries the first doubleword in bits [63:0] and the second in [127:64]. Slots 0..7 are read in ascending order, one per transaction, and the walk stops at the first match. A request holds its address until `rd_ack_i`.
- R5: An entry matches when its first doubleword equals the tag in these fields: bit 0 valid (must be 1), bit 1 secondary flag, bit 2 segment size, bits [31:8] VSID, and bits [55:32] ((page-aligned segment offset) >> 16)[23:0]. Bits [7:3] and [63:56] are ignored.
- R6: After eight primary misses, the walker reads the group (~hash AND mask), and the tag there requires the secondary flag (bit 1) set.
- R7: On a hit, the new second doubleword is the old value OR bit 0 (referenced), and also OR bit 1 (changed) when `is_store_i` is set. It is written to the entry address + 8 only when it differs from the old value, and `done_o` follows the write acknowledge.
- R8: On a hit, `ra_o` takes bits [63:12] from the second doubleword. Bits below the page shift come from the EA instead, and bits [11:0] always come from the EA.
- R9: With `force_small_i` set, the page shift is 12 whatever `pshift_i` holds.
- R10: A walk with no match makes exactly 16 reads, performs no write, and completes with `hit_o`=0, `ptex_o`=0 and `ra_o`=0.
- R11: `done_o` is high for exactly one cycle per walk. `busy_o` is high from the cycle after the accepted start through the done cycle. `start_i` is ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk (accepted only when idle) |
| vsid_i | input | 24 | Virtual segment ID |
| seg_1t_i | input | 1 | Segment size: 1 = 1 TB, 0 = 256 MB |
| ea_i | input | EA_W | Effective address |
| pshift_i | input | 6 | Base page shift |
| force_small_i | input | 1 | Force page shift to 12 |
| is_store_i | input | 1 | Access is a store |
| htab_base_i | input | AW | Table base byte address |
| htab_mask_i | input | HASH_W | Hash mask selecting group count |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | One-cycle completion strobe |
| hit_o | output | 1 | Walk found a matching entry |
| ptex_o | output | HASH_W+3 | Index of the matching entry |
| ra_o | output | 64 | Translated real address |
| rd_req_o | output | 1 | Entry read request |
| rd_addr_o | output | AW | Entry read address |
| rd_ack_i | input | 1 | Read data valid |
| rd_data_i | input | 128 | Entry pair {second, first} |
| wr_req_o | output | 1 | Second-doubleword write request |
| wr_addr_o | output | AW | Write address |
| wr_data_o | output | 64 | Updated second doubleword |
| wr_ack_i | input | 1 | Write complete |

## Verification
Random walks cover both segment sizes, several page shifts, random masks and bases, and random read/write acknowledge delays. Each walk draws one of three outcomes: a hit in the primary group, a hit in the secondary group, or a miss. Entries ahead of the match are decoys, each with exactly one compared field wrong (valid, secondary flag, segment size, a VSID bit or an AVPN bit), while the matching entry carries random ignored bits. This separates the compared fields from the ignored ones, and the early-stop order from a full-group scan. The exact read address sequence pins down the hash, which tells a wrong segment-size formula, page shift or forced-small handling apart from a correct one. Directed runs add a zero mask, where both groups alias to the same group, every referenced/changed combination on loads and stores, and a start pulse issued mid-walk.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int DW             = 64;
  localparam int V_BIT          = 0;
  localparam int H_BIT          = 1;
  localparam int B_BIT          = 2;
  localparam int VSID_LSB       = 8;
  localparam int VSID_W         = 24;
  localparam int AVPN_LSB       = 32;
  localparam int AVPN_W         = 24;
  localparam int AVPN_SHIFT     = 16;
  localparam int REF_BIT        = 0;
  localparam int CHG_BIT        = 1;
  localparam int RPN_LSB        = 12;
  localparam int SEG_SMALL_BITS = 28;
  localparam int SEG_LARGE_BITS = 40;
  localparam int LARGE_VSID_ROT = 25;
  localparam int GROUP_SLOTS    = 8;
  localparam int SLOT_W         = $clog2(GROUP_SLOTS);
  localparam int ENTRY_SHIFT    = 4;
  localparam int SMALL_SHIFT    = 12;

  localparam logic [DW-1:0] CMP_MASK =
      ((((DW)'(1) << AVPN_W) - (DW)'(1)) << AVPN_LSB) |
      ((((DW)'(1) << VSID_W) - (DW)'(1)) << VSID_LSB) |
      ((DW)'(1) << V_BIT) | ((DW)'(1) << H_BIT) | ((DW)'(1) << B_BIT);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CHECK,
    ST_WRITE,
    ST_DONE
  } walk_state_e;
endpackage

// File: rtl/hpt_hash.sv
module hpt_hash
  import hpt_pkg::*;
#(
  parameter int HASH_W = 16
) (
  input  logic [VSID_W-1:0]         vsid_i,
  input  logic                      seg_1t_i,
  input  logic [SEG_LARGE_BITS-1:0] ea_i,
  input  logic [5:0]                shift_i,
  output logic [HASH_W-1:0]         hash_o,
  output logic [DW-1:0]             tag_o
);
  logic [DW-1:0] low_mask, seg_off, epn, page, vx;

  always_comb begin
    low_mask = ((DW)'(1) << shift_i) - (DW)'(1);
    seg_off  = seg_1t_i ? (DW)'(ea_i) : (DW)'(ea_i[SEG_SMALL_BITS-1:0]);
    epn      = seg_off & ~low_mask;
    page     = epn >> shift_i;
    vx       = (DW)'(vsid_i);
    hash_o   = seg_1t_i ? HASH_W'(vx ^ (vx << LARGE_VSID_ROT) ^ page)
                        : HASH_W'(vx ^ page);
    tag_o    = ((DW)'(1) << V_BIT) |
               ((DW)'(seg_1t_i) << B_BIT) |
               (vx << VSID_LSB) |
               ((DW)'(AVPN_W'(epn >> AVPN_SHIFT)) << AVPN_LSB);
  end
endmodule

// File: rtl/hpt_match.sv
module hpt_match
  import hpt_pkg::*;
(
  input  logic [DW-1:0] entry_i,
  input  logic [DW-1:0] tag_i,
  output logic          hit_o
);
  assign hit_o = ((entry_i ^ tag_i) & CMP_MASK) == '0;
endmodule

// File: rtl/hpt_ra.sv
module hpt_ra
  import hpt_pkg::*;
#(
  parameter int EA_W = 48
) (
  input  logic [EA_W-1:0]       ea_i,
  input  logic [DW-1:RPN_LSB]   rpn_i,
  input  logic [5:0]            shift_i,
  output logic [DW-1:0]         ra_o
);
  for (genvar g = 0; g < DW; g++) begin : g_bit
    if (g < RPN_LSB) begin : g_off
      assign ra_o[g] = ea_i[g];
    end else if (g < EA_W) begin : g_mix
      assign ra_o[g] = (shift_i > 6'(g)) ? ea_i[g] : rpn_i[g];
    end else begin : g_rpn
      assign ra_o[g] = rpn_i[g];
    end
  end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int EA_W   = 48,
  parameter int AW     = 48,
  parameter int HASH_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [VSID_W-1:0]        vsid_i,
  input  logic                     seg_1t_i,
  input  logic [EA_W-1:0]          ea_i,
  input  logic [5:0]               pshift_i,
  input  logic                     force_small_i,
  input  logic                     is_store_i,
  input  logic [AW-1:0]            htab_base_i,
  input  logic [HASH_W-1:0]        htab_mask_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     hit_o,
  output logic [HASH_W+SLOT_W-1:0] ptex_o,
  output logic [DW-1:0]            ra_o,
  output logic                     rd_req_o,
  output logic [AW-1:0]            rd_addr_o,
  input  logic                     rd_ack_i,
  input  logic [2*DW-1:0]          rd_data_i,
  output logic                     wr_req_o,
  output logic [AW-1:0]            wr_addr_o,
  output logic [DW-1:0]            wr_data_o,
  input  logic                     wr_ack_i
);
  localparam int PTEX_W = HASH_W + SLOT_W;
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(GROUP_SLOTS - 1);

  walk_state_e         state_q;
  logic [VSID_W-1:0]   vsid_q;
  logic                seg_q, store_q, phase_q, hit_q;
  logic [EA_W-1:0]     ea_q;
  logic [5:0]          shift_q;
  logic [AW-1:0]       base_q;
  logic [HASH_W-1:0]   mask_q;
  logic [SLOT_W-1:0]   slot_q;
  logic [DW-1:0]       d0_q, d1_q, wdata_q, ra_q;
  logic [PTEX_W-1:0]   ptex_q;

  logic [HASH_W-1:0]   hash, grp;
  logic [DW-1:0]       tag_base, tag, ra_calc, d1_upd;
  logic [PTEX_W-1:0]   ptex_cur;
  logic [AW-1:0]       entry_addr;
  logic                entry_hit;

  hpt_hash #(.HASH_W(HASH_W)) u_hash (
    .vsid_i  (vsid_q),
    .seg_1t_i(seg_q),
    .ea_i    (ea_q[SEG_LARGE_BITS-1:0]),
    .shift_i (shift_q),
    .hash_o  (hash),
    .tag_o   (tag_base)
  );

  // secondary pass: complemented hash, flag set in the tag
  assign tag        = tag_base | ((DW)'(phase_q) << H_BIT);
  assign grp        = phase_q ? (~hash & mask_q) : (hash & mask_q);
  assign ptex_cur   = {grp, slot_q};
  assign entry_addr = base_q + (AW'(ptex_cur) << ENTRY_SHIFT);

  hpt_match u_match (
    .entry_i(d0_q),
    .tag_i  (tag),
    .hit_o  (entry_hit)
  );

  hpt_ra #(.EA_W(EA_W)) u_ra (
    .ea_i   (ea_q),
    .rpn_i  (d1_q[DW-1:RPN_LSB]),
    .shift_i(shift_q),
    .ra_o   (ra_calc)
  );

  assign d1_upd = d1_q | ((DW)'(1) << REF_BIT) | ((DW)'(store_q) << CHG_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      vsid_q  <= '0;
      seg_q   <= 1'b0;
      store_q <= 1'b0;
      ea_q    <= '0;
      shift_q <= '0;
      base_q  <= '0;
      mask_q  <= '0;
      phase_q <= 1'b0;
      slot_q  <= '0;
      d0_q    <= '0;
      d1_q    <= '0;
      wdata_q <= '0;
      hit_q   <= 1'b0;
      ptex_q  <= '0;
      ra_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            vsid_q  <= vsid_i;
            seg_q   <= seg_1t_i;
            store_q <= is_store_i;
            ea_q    <= ea_i;
            shift_q <= force_small_i ? 6'(SMALL_SHIFT) : pshift_i;
            base_q  <= htab_base_i;
            mask_q  <= htab_mask_i;
            phase_q <= 1'b0;
            slot_q  <= '0;
            hit_q   <= 1'b0;
            ptex_q  <= '0;
            ra_q    <= '0;
            state_q <= ST_READ;
          end
        end
        ST_READ: begin
          if (rd_ack_i) begin
            d0_q    <= rd_data_i[DW-1:0];
            d1_q    <= rd_data_i[2*DW-1:DW];
            state_q <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (entry_hit) begin
            hit_q   <= 1'b1;
            ptex_q  <= ptex_cur;
            ra_q    <= ra_calc;
            wdata_q <= d1_upd;
            state_q <= (d1_upd != d1_q) ? ST_WRITE : ST_DONE;
          end else if (slot_q == LAST_SLOT) begin
            if (phase_q) begin
              state_q <= ST_DONE;
            end else begin
              phase_q <= 1'b1;
              slot_q  <= '0;
              state_q <= ST_READ;
            end
          end else begin
            slot_q  <= slot_q + 1'b1;
            state_q <= ST_READ;
          end
        end
        ST_WRITE: begin
          if (wr_ack_i) state_q <= ST_DONE;
        end
        ST_DONE:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = state_q != ST_IDLE;
  assign done_o    = state_q == ST_DONE;
  assign hit_o     = hit_q;
  assign ptex_o    = ptex_q;
  assign ra_o      = ra_q;
  assign rd_req_o  = state_q == ST_READ;
  assign rd_addr_o = entry_addr;
  assign wr_req_o  = state_q == ST_WRITE;
  assign wr_addr_o = entry_addr + AW'(8);
  assign wr_data_o = wdata_q;
endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk
  import hpt_pkg::*;
#(
  parameter int EA_W   = 48,
  parameter int AW     = 48,
  parameter int HASH_W = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     busy_o,
  input logic                     done_o,
  input logic                     hit_o,
  input logic [HASH_W+SLOT_W-1:0] ptex_o,
  input logic [DW-1:0]            ra_o,
  input logic                     rd_req_o,
  input logic [AW-1:0]            rd_addr_o,
  input logic                     rd_ack_i,
  input logic                     wr_req_o,
  input logic [AW-1:0]            wr_addr_o,
  input logic [DW-1:0]            wr_data_o,
  input logic                     wr_ack_i
);
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!rd_req_o && !wr_req_o && !done_o));

  a_r4_one_port: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_o && wr_req_o));

  a_r4_rd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o)));

  a_r7_wr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && !wr_ack_i) |=> (wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  a_r7_wr_ref: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> wr_data_o[REF_BIT]);

  a_r7_wr_then_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && wr_ack_i) |=> done_o);

  a_r10_miss_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !hit_o) |-> (ptex_o == '0 && ra_o == '0));

  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r11_done_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
endmodule

bind hpt_walker hpt_walker_chk #(.EA_W(EA_W), .AW(AW), .HASH_W(HASH_W)) u_chk (.*);

// File: tb/hpt_walker_tb.sv
`timescale 1ns/1ps
module hpt_walker_tb_top;
  localparam int EA_W = 48, AW = 48, HASH_W = 16, PTEX_W = HASH_W + 3;
  localparam logic [63:0] TB_CMP = 64'h00FF_FFFF_FFFF_FF07;
  localparam logic [63:0] TB_IGN = 64'hFF00_0000_0000_00F8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  always #2 clk_i = ~clk_i;

  logic start_i = 0, seg_1t_i = 0, force_small_i = 0, is_store_i = 0;
  logic [23:0] vsid_i = '0;
  logic [EA_W-1:0] ea_i = '0;
  logic [5:0] pshift_i = 6'd12;
  logic [AW-1:0] htab_base_i = '0;
  logic [HASH_W-1:0] htab_mask_i = '0;
  logic busy_o, done_o, hit_o, rd_req_o, wr_req_o;
  logic rd_ack_i = 0, wr_ack_i = 0;
  logic [PTEX_W-1:0] ptex_o;
  logic [63:0] ra_o, wr_data_o;
  logic [AW-1:0] rd_addr_o, wr_addr_o;
  logic [127:0] rd_data_i = '0;

  hpt_walker #(.EA_W(EA_W), .AW(AW), .HASH_W(HASH_W)) dut_i (.*);

  int n_chk = 0, n_fail = 0;
  logic [AW-1:0] m_addr[32];
  logic [63:0] m_d0[32], m_d1[32];
  int m_n = 0;
  logic [AW-1:0] rd_log[40];
  int n_rd = 0, n_wr = 0, n_done = 0, rd_wait = 0, wr_wait = 0;
  logic [AW-1:0] wr_log_addr;
  logic [63:0] wr_log_data;
  logic [AW-1:0] e_rd[16];
  int e_nrd;
  bit e_hit, e_wr;
  logic [PTEX_W-1:0] e_ptex;
  logic [63:0] e_ra, e_wdata;
  logic [AW-1:0] e_waddr;

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  function automatic int mem_find(logic [AW-1:0] a);
    for (int i = 0; i < m_n; i++) if (m_addr[i] == a) return i;
    return -1;
  endfunction

  task automatic plant(logic [AW-1:0] a, logic [63:0] d0, logic [63:0] d1);
    int i;
    i = mem_find(a);
    if (i < 0 && m_n < 32) begin i = m_n; m_n++; end
    if (i >= 0) begin m_addr[i] = a; m_d0[i] = d0; m_d1[i] = d1; end
  endtask

  function automatic int eff_shift();
    return force_small_i ? 12 : int'(pshift_i);
  endfunction

  // R2 / R3 hash formulas
  function automatic logic [63:0] ref_hash();
    logic [63:0] off, vv;
    off = seg_1t_i ? {24'b0, ea_i[39:0]} : {36'b0, ea_i[27:0]};
    vv = {40'b0, vsid_i};
    return seg_1t_i ? (vv ^ (vv << 25) ^ (off >> eff_shift())) : (vv ^ (off >> eff_shift()));
  endfunction

  // R5 tag layout
  function automatic logic [63:0] ref_tag(bit sec);
    logic [63:0] off, al, av;
    off = seg_1t_i ? {24'b0, ea_i[39:0]} : {36'b0, ea_i[27:0]};
    al = (off >> eff_shift()) << eff_shift();
    av = (al >> 16) & 64'hFF_FFFF;
    return 64'd1 | (64'(sec) << 1) | (64'(seg_1t_i) << 2) | ({40'b0, vsid_i} << 8) | (av << 32);
  endfunction

  function automatic logic [HASH_W-1:0] ref_grp(bit sec);
    logic [63:0] h;
    h = ref_hash();
    return sec ? (~h[HASH_W-1:0] & htab_mask_i) : (h[HASH_W-1:0] & htab_mask_i);
  endfunction

  function automatic logic [AW-1:0] ref_addr(logic [HASH_W-1:0] g, int s);
    return htab_base_i + (AW'({g, 3'(s)}) << 4);
  endfunction

  task automatic compute_expected();
    logic [63:0] low, d0, d1, nd1, tg;
    logic [HASH_W-1:0] g;
    logic [AW-1:0] a;
    int idx;
    e_nrd = 0; e_hit = 0; e_wr = 0; e_ptex = '0; e_ra = '0; e_wdata = '0; e_waddr = '0;
    low = (64'd1 << eff_shift()) - 64'd1;
    for (int ph = 0; ph < 2; ph++) begin
      if (e_hit) break;
      g = ref_grp(ph[0]);
      tg = ref_tag(ph[0]);
      for (int s = 0; s < 8; s++) begin
        a = ref_addr(g, s);
        e_rd[e_nrd] = a; e_nrd++;
        idx = mem_find(a);
        d0 = (idx >= 0) ? m_d0[idx] : 64'd0;
        d1 = (idx >= 0) ? m_d1[idx] : 64'd0;
        if (((d0 ^ tg) & TB_CMP) == 64'd0) begin
          e_hit = 1;
          e_ptex = {g, 3'(s)};
          e_ra = ((d1 & ~64'hFFF) & ~low) | ({16'b0, ea_i} & (low | 64'hFFF));
          nd1 = d1 | 64'd1 | (is_store_i ? 64'd2 : 64'd0);
          e_wr = (nd1 != d1);
          e_wdata = nd1;
          e_waddr = a + AW'(8);
          break;
        end
      end
    end
  endtask

  function automatic logic [63:0] decoy(logic [63:0] tg);
    logic [63:0] d;
    d = tg | (rnd64() & TB_IGN);
    case ($urandom % 5)
      0: d[0] = 1'b0;
      1: d[1] = ~d[1];
      2: d[2] = ~d[2];
      3: d[8 + ($urandom % 24)] ^= 1'b1;
      default: d[32 + ($urandom % 24)] ^= 1'b1;
    endcase
    return d;
  endfunction

  // kind: 0 miss, 1 primary hit, 2 secondary hit
  task automatic plant_case(int kind, int slot);
    int np, ns;
    np = (kind == 1) ? slot : 8;
    ns = (kind == 2) ? slot : ((kind == 0) ? 8 : 0);
    for (int s = 0; s < np; s++) plant(ref_addr(ref_grp(0), s), decoy(ref_tag(0)), rnd64());
    for (int s = 0; s < ns; s++) plant(ref_addr(ref_grp(1), s), decoy(ref_tag(1)), rnd64());
    if (kind != 0)
      plant(ref_addr(ref_grp(kind == 2), slot), ref_tag(kind == 2) | (rnd64() & TB_IGN), rnd64());
  endtask

  // memory responder and done counter
  initial begin
    forever begin
      @(negedge clk_i);
      if (done_o) n_done++;
      if (rd_ack_i) rd_ack_i = 0;
      else if (rd_req_o) begin
        if (rd_wait == 0) begin
          int i;
          if (n_rd < 40) rd_log[n_rd] = rd_addr_o;
          n_rd++;
          i = mem_find(rd_addr_o);
          rd_data_i = (i >= 0) ? {m_d1[i], m_d0[i]} : 128'd0;
          rd_ack_i = 1;
          rd_wait = $urandom % 3;
        end else rd_wait--;
      end
      if (wr_ack_i) wr_ack_i = 0;
      else if (wr_req_o) begin
        if (wr_wait == 0) begin
          n_wr++;
          wr_log_addr = wr_addr_o;
          wr_log_data = wr_data_o;
          wr_ack_i = 1;
          wr_wait = $urandom % 3;
        end else wr_wait--;
      end
    end
  end

  task automatic run_one(string tag, bit restart);
    int t;
    bit rd_ok;
    compute_expected();
    n_rd = 0; n_wr = 0; n_done = 0;
    @(negedge clk_i); start_i = 1;
    @(negedge clk_i); start_i = 0;
    check(busy_o == 1'b1, {tag, " R11 busy after start"}, 64'(busy_o), 64'd1);
    if (restart) begin
      repeat (3) @(negedge clk_i);
      vsid_i = ~vsid_i; start_i = 1;
      @(negedge clk_i); start_i = 0;
    end
    t = 0;
    while (done_o !== 1'b1 && t < 3000) begin @(negedge clk_i); t++; end
    check(t < 3000, {tag, " R11 done reached"}, 64'(t), 64'd3000);
    check(hit_o == e_hit, {tag, " R5 R6 hit status"}, 64'(hit_o), 64'(e_hit));
    check(ptex_o == e_ptex, {tag, " R4 R10 entry index"}, 64'(ptex_o), 64'(e_ptex));
    check(ra_o == e_ra, {tag, " R8 R10 real address"}, ra_o, e_ra);
    @(negedge clk_i);
    check(!busy_o && !done_o, {tag, " R11 idle after done"}, {62'd0, busy_o, done_o}, 64'd0);
    if (restart) repeat (20) @(negedge clk_i);
    check(n_done == 1, {tag, " R11 one done pulse"}, 64'(n_done), 64'd1);
    check(n_rd == e_nrd, {tag, " R4 R10 read count"}, 64'(n_rd), 64'(e_nrd));
    rd_ok = 1;
    for (int i = 0; i < e_nrd && i < n_rd; i++)
      if (rd_log[i] != e_rd[i]) begin
        rd_ok = 0;
        check(0, {tag, " R2 R3 R4 read address"}, 64'(rd_log[i]), 64'(e_rd[i]));
        break;
      end
    if (rd_ok) check(1, {tag, " R4 read order"}, 64'd0, 64'd0);
    check(n_wr == int'(e_wr), {tag, " R7 write count"}, 64'(n_wr), 64'(e_wr));
    if (e_wr && n_wr == 1) begin
      check(wr_log_data == e_wdata, {tag, " R7 write data"}, wr_log_data, e_wdata);
      check(wr_log_addr == e_waddr, {tag, " R7 write address"}, 64'(wr_log_addr), 64'(e_waddr));
    end
  endtask

  task automatic set_inputs(logic [23:0] v, bit s1t, int ps, bit frc, bit st, logic [HASH_W-1:0] mk);
    logic [63:0] r;
    vsid_i = v; seg_1t_i = s1t; pshift_i = 6'(ps); force_small_i = frc; is_store_i = st;
    htab_mask_i = mk;
    r = rnd64(); ea_i = r[EA_W-1:0];
    r = rnd64(); htab_base_i = {r[AW-1:4], 4'b0};
    m_n = 0;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    check(0, "R11 watchdog", 64'd1, 64'd0);
    summary();
    $finish;
  end

  initial begin
    int ps_tab[3];
    ps_tab[0] = 12; ps_tab[1] = 16; ps_tab[2] = 24;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    check({busy_o, done_o, rd_req_o, wr_req_o} == 4'b0, "R1 in reset", 64'({busy_o, done_o, rd_req_o, wr_req_o}), 64'd0);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    check({busy_o, done_o, rd_req_o, wr_req_o} == 4'b0, "R1 idle", 64'({busy_o, done_o, rd_req_o, wr_req_o}), 64'd0);

    // R2 R5: small segment, primary hit at slot 3 behind decoys
    set_inputs(24'h5A_1234, 0, 12, 0, 0, 16'hFFFF);
    plant_case(1, 3);
    run_one("R2 R5 primary", 0);

    // R3 R6: large segment, secondary hit at last slot
    set_inputs(24'hC3_0F0F, 1, 16, 0, 1, 16'h3FFF);
    plant_case(2, 7);
    run_one("R3 R6 secondary", 0);

    // R9: shift 24 forced to 12
    set_inputs(24'h01_2345, 1, 24, 1, 0, 16'hFFFF);
    plant_case(1, 0);
    run_one("R9 forced small", 0);

    // R10: zero mask aliases both groups, empty table
    set_inputs(24'h77_7777, 0, 16, 0, 0, 16'h0000);
    run_one("R10 zero mask miss", 0);

    // R7: referenced already set, store adds changed
    set_inputs(24'h10_2030, 0, 12, 0, 1, 16'h00FF);
    plant(ref_addr(ref_grp(0), 0), ref_tag(0), 64'hABCD_E000_0000_0001);
    run_one("R7 store sets changed", 0);
    set_inputs(24'h10_2030, 0, 12, 0, 1, 16'h00FF);
    plant(ref_addr(ref_grp(0), 0), ref_tag(0), 64'hABCD_E000_0000_0003);
    run_one("R7 store no write", 0);
    set_inputs(24'h10_2030, 0, 12, 0, 0, 16'h00FF);
    plant(ref_addr(ref_grp(0), 0), ref_tag(0), 64'hABCD_E000_0000_0001);
    run_one("R7 load no write", 0);

    // R11: start during busy is ignored
    set_inputs(24'h33_4455, 1, 12, 0, 0, 16'hFFFF);
    run_one("R11 restart ignored", 1);

    for (int n = 0; n < 60; n++) begin
      logic [63:0] r;
      r = rnd64();
      set_inputs(r[23:0], r[24], ps_tab[$urandom % 3], ($urandom % 6) == 0, r[25], r[47:32]);
      plant_case($urandom % 3, $urandom % 8);
      run_one("R4 R5 R8 random", 0);
    end

    summary();
    $finish;
  end
endmodule